// File: doc/BRIEF.md
# Sequence-Numbered MMIO Reorder Buffer

This block sits where processor MMIO traffic enters the I/O fabric. The core stamps every MMIO access with an 8-bit sequence number in program order and does not stall to enforce ordering. Operations may therefore arrive here in any order. There are four access kinds: a plain store, a release store, a plain load and an acquire load.

Arriving operations are parked in a 16-slot buffer. A slot is chosen by the low four bits of the sequence number. Each cycle the buffer selects at most one operation toward the device. It picks the oldest operation that its ordering rule currently allows. Everything else is free to go early, so plain stores drain the way write-combined stores would.

Load data that comes back from the device is handed to the processor side one cycle later. It carries the sequence number of the load it answers.

The window base is the oldest sequence number that has not yet been emitted and retired. It moves forward by one per cycle over emitted slots, wrapping modulo 256.

Top module: `mmio_rob`

## Requirements
- R1: After reset, no operation is offered downstream, no load return is valid, and the window base is sequence 0. So sequence 15 is accepted and sequence 16 is refused.
- R2: An arriving operation is refused (in_ready low) when its sequence number minus the window base, modulo 256, is 16 or more. It is accepted when that distance is below 16 and its slot is free.
- R3: A plain store (kind code 0) may be emitted as soon as it has arrived, regardless of any earlier operations that are missing or pending.
- R4: A release store (kind code 1) is not emitted until every lower sequence number in the window has arrived and each of them is either a load (kind 2 or 3) or already emitted.
- R5: A load (kind code 2 or 3) is not emitted until every lower sequence number in the window has arrived and none of them is an acquire load (kind code 3) still waiting to be emitted.
- R6: Loads impose no ordering on plain stores. A plain store with a higher sequence number may leave ahead of a blocked or missing load.
- R7: At most one operation is emitted per cycle. Among the operations allowed to leave, the one with the lowest sequence number relative to the window base is offered. Every accepted operation is emitted exactly once, with its kind, address and data unchanged.
- R8: While out_valid is high and out_ready is low, the offered operation stays the same, even if an older operation arrives meanwhile.
- R9: A device load response is presented to the processor side on the following cycle, with the same sequence number and data.
- R10: Sequence numbers and the window base wrap from 255 to 0 without loss or reordering errors. The base never advances by more than one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Processor-side operation present |
| in_ready | output | 1 | Operation can be accepted this cycle |
| in_seq | input | 8 | Program-order sequence number |
| in_kind | input | 2 | 0 store, 1 release store, 2 load, 3 acquire load |
| in_addr | input | 16 | MMIO address |
| in_data | input | 32 | Store data (ignored for loads) |
| out_valid | output | 1 | Operation offered to the device |
| out_ready | input | 1 | Device takes the offered operation |
| out_seq | output | 8 | Sequence number of the offered operation |
| out_kind | output | 2 | Kind of the offered operation |
| out_addr | output | 16 | Address of the offered operation |
| out_data | output | 32 | Data of the offered operation |
| dev_rsp_valid | input | 1 | Device returns load data |
| dev_rsp_seq | input | 8 | Sequence number of the answered load |
| dev_rsp_data | input | 32 | Returned load data |
| cpu_ret_valid | output | 1 | Load data returned to the processor side |
| cpu_ret_seq | output | 8 | Sequence number of the returned load |
| cpu_ret_data | output | 32 | Returned load data |

## Verification
The bench targets gaps in the sequence space. These are a release store, or a load, whose earlier neighbour has not yet arrived. A design that treated a missing slot as harmless would let a release overtake an unseen store, or let a load overtake an unseen acquire.

It also targets an older operation arriving while a younger one is stalled downstream. A design without a hold would swap the offered payload under back-pressure.

Shuffled batches of 16 cover the whole window and wrap the sequence space twice. There the checks catch slot aliasing or a base that stalls at the wrap, which would show up as a duplicate or a missing emission. A refusal check at distances 16 and 255 catches an off-by-one window.

// File: rtl/mmio_rob.sv
module mmio_rob #(
  parameter int SEQ_W  = 8,
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SEQ_W-1:0]  in_seq,
  input  logic [1:0]        in_kind,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SEQ_W-1:0]  out_seq,
  output logic [1:0]        out_kind,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  input  logic              dev_rsp_valid,
  input  logic [SEQ_W-1:0]  dev_rsp_seq,
  input  logic [DATA_W-1:0] dev_rsp_data,
  output logic              cpu_ret_valid,
  output logic [SEQ_W-1:0]  cpu_ret_seq,
  output logic [DATA_W-1:0] cpu_ret_data
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [1:0] K_ST  = 2'd0;
  localparam logic [1:0] K_REL = 2'd1;
  localparam logic [1:0] K_ACQ = 2'd3;

  logic [SEQ_W-1:0]  head;
  logic [DEPTH-1:0]  pend, done;
  logic [1:0]        kind_q [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic              hold_v, found;
  logic [IDX_W-1:0]  hold_idx, sel_idx, out_idx;

  wire [IDX_W-1:0] hidx    = head[IDX_W-1:0];
  wire [IDX_W-1:0] in_idx  = in_seq[IDX_W-1:0];
  wire [SEQ_W-1:0] in_dist = in_seq - head;

  assign in_ready = (in_dist[SEQ_W-1:IDX_W] == '0) && !pend[in_idx] && !done[in_idx];
  wire accept = in_valid && in_ready;

  always_comb begin
    logic [IDX_W-1:0] idx;
    logic [1:0]       kd;
    logic             arr, elig, sgap, agap;
    found = 1'b0;
    sel_idx = '0;
    sgap = 1'b0;
    agap = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      idx  = hidx + IDX_W'(k);
      kd   = kind_q[idx];
      arr  = pend[idx] | done[idx];
      elig = pend[idx] && ((kd == K_ST) || (kd == K_REL && !sgap) || (kd[1] && !agap));
      if (elig && !found) begin
        found   = 1'b1;
        sel_idx = idx;
      end
      if (!arr || (!kd[1] && !done[idx])) sgap = 1'b1;
      if (!arr || (kd == K_ACQ && !done[idx])) agap = 1'b1;
    end
  end

  assign out_idx   = hold_v ? hold_idx : sel_idx;
  assign out_valid = hold_v | found;
  assign out_seq   = head + {{(SEQ_W-IDX_W){1'b0}}, IDX_W'(out_idx - hidx)};
  assign out_kind  = kind_q[out_idx];
  assign out_addr  = addr_q[out_idx];
  assign out_data  = data_q[out_idx];

  wire fire   = out_valid && out_ready;
  wire retire = done[hidx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head     <= '0;
      pend     <= '0;
      done     <= '0;
      hold_v   <= 1'b0;
      hold_idx <= '0;
      for (int i = 0; i < DEPTH; i++) kind_q[i] <= K_ST;
    end else begin
      hold_v   <= out_valid && !out_ready;
      hold_idx <= out_idx;
      if (accept) begin
        pend[in_idx]   <= 1'b1;
        kind_q[in_idx] <= in_kind;
      end
      if (fire) begin
        pend[out_idx] <= 1'b0;
        done[out_idx] <= 1'b1;
      end
      if (retire) begin
        done[hidx] <= 1'b0;
        head       <= head + SEQ_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q[in_idx] <= in_addr;
      data_q[in_idx] <= in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_ret_valid <= 1'b0;
      cpu_ret_seq   <= '0;
      cpu_ret_data  <= '0;
    end else begin
      cpu_ret_valid <= dev_rsp_valid;
      cpu_ret_seq   <= dev_rsp_seq;
      cpu_ret_data  <= dev_rsp_data;
    end
  end

  // R8
  stable_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_seq) && $stable(out_addr) && $stable(out_data));

  // R9
  ret_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rsp_valid |=> cpu_ret_valid && cpu_ret_seq == $past(dev_rsp_seq) && cpu_ret_data == $past(dev_rsp_data));

  // R10
  head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (head == $past(head) || head == $past(head) + SEQ_W'(1)));

  // R3
  emit_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> pend[out_idx]);

  // R7
  fire_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !pend[$past(out_idx)]);
endmodule

// File: tb/mmio_rob_tb_top.sv
module mmio_rob_tb_top;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0, dev_rsp_valid = 0;
  logic [7:0] in_seq = 0, dev_rsp_seq = 0;
  logic [1:0] in_kind = 0;
  logic [15:0] in_addr = 0;
  logic [31:0] in_data = 0, dev_rsp_data = 0;
  logic in_ready, out_valid, cpu_ret_valid;
  logic [7:0] out_seq, cpu_ret_seq;
  logic [1:0] out_kind;
  logic [15:0] out_addr;
  logic [31:0] out_data, cpu_ret_data;

  int checks = 0, errors = 0, total_emit = 0;
  bit mon_en = 0, finished = 0;
  int base_abs = 0;
  bit em [16];

  always #4 clk = ~clk;

  mmio_rob dut_i (.*);

  function automatic logic [1:0] kindf(input int a);
    return 2'((a * 5 + (a >> 2)) & 3);
  endfunction
  function automatic logic [15:0] addrf(input int a);
    return 16'(a) ^ 16'hA5A5;
  endfunction
  function automatic logic [31:0] dataf(input int a);
    return 32'(a) * 32'h0100_0193;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input int a, input logic [1:0] k);
    @(negedge clk);
    in_valid = 1; in_seq = 8'(a); in_kind = k; in_addr = addrf(a); in_data = dataf(a);
    @(negedge clk);
    in_valid = 0;
    #1;
  endtask

  task automatic step;
    @(negedge clk);
    #1;
  endtask

  // emission monitor for the shuffled batches
  always @(negedge clk) begin
    #3;
    if (mon_en && out_valid && out_ready) begin
      int o, a;
      bit ord_ok;
      o = int'(8'(out_seq - 8'(base_abs)));
      a = base_abs + o;
      total_emit++;
      chk(o < 16 && !em[o] && out_kind == kindf(a) && out_addr == addrf(a) && out_data == dataf(a),
          "R7 single intact emission", {out_kind, 6'd0, out_seq, out_addr}, {kindf(a), 6'd0, 8'(a), addrf(a)});
      ord_ok = 1;
      for (int j = 0; j < o && j < 16; j++) begin
        if (out_kind == 2'd1 && !kindf(base_abs + j)[1] && !em[j]) ord_ok = 0;
        if (out_kind[1] && kindf(base_abs + j) == 2'd3 && !em[j]) ord_ok = 0;
      end
      if (out_kind == 2'd1) chk(ord_ok, "R4 release after earlier stores", 32'(out_seq), 32'(o));
      else if (out_kind[1]) chk(ord_ok, "R5 load after earlier acquires", 32'(out_seq), 32'(o));
      else chk(ord_ok, "R6 plain store free", 32'(out_seq), 32'(o));
      if (o < 16) em[o] = 1;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(!out_valid && !cpu_ret_valid, "R1 idle after reset", {out_valid, cpu_ret_valid}, 0);
    in_seq = 15; #1; chk(in_ready, "R1 seq 15 accepted", in_ready, 1);
    in_seq = 16; #1; chk(!in_ready, "R1 R2 seq 16 refused", in_ready, 0);

    send(3, 2'd0);
    chk(out_valid && out_seq == 3, "R3 lone store emitted", out_seq, 3);
    send(1, 2'd0);
    chk(out_valid && out_seq == 3, "R8 held under backpressure", out_seq, 3);
    @(negedge clk); out_ready = 1;
    step; chk(out_valid && out_seq == 1, "R7 next oldest", out_seq, 1);
    step; chk(!out_valid, "R7 drained", out_valid, 0); out_ready = 0;

    send(2, 2'd1);
    chk(!out_valid, "R4 release blocked by missing seq 0", out_valid, 0);
    send(0, 2'd2);
    chk(out_valid && out_seq == 0, "R7 oldest eligible first", out_seq, 0);
    @(negedge clk); out_ready = 1;
    step; chk(out_valid && out_seq == 2 && out_kind == 2'd1, "R4 release freed", out_seq, 2);
    step; chk(!out_valid, "R4 drained", out_valid, 0); out_ready = 0;

    send(5, 2'd2);
    chk(!out_valid, "R5 load blocked by missing seq 4", out_valid, 0);
    send(4, 2'd3);
    chk(out_valid && out_seq == 4, "R5 acquire first", out_seq, 4);
    @(negedge clk); out_ready = 1;
    step; chk(out_valid && out_seq == 5, "R5 load after acquire", out_seq, 5);
    step; chk(!out_valid, "R5 drained", out_valid, 0); out_ready = 0;

    send(7, 2'd2);
    chk(!out_valid, "R5 load blocked by missing seq 6", out_valid, 0);
    send(8, 2'd0);
    chk(out_valid && out_seq == 8, "R6 store passes blocked load", out_seq, 8);
    send(6, 2'd2);
    chk(out_valid && out_seq == 8, "R8 older arrival does not displace", out_seq, 8);
    @(negedge clk); out_ready = 1;
    step; chk(out_valid && out_seq == 6, "R7 seq 6 next", out_seq, 6);
    step; chk(out_valid && out_seq == 7, "R7 seq 7 next", out_seq, 7);
    step; chk(!out_valid, "R7 drained", out_valid, 0); out_ready = 0;

    repeat (12) @(negedge clk);
    #1;
    in_seq = 24; #1; chk(in_ready, "R2 distance 15 accepted", in_ready, 1);
    in_seq = 25; #1; chk(!in_ready, "R2 distance 16 refused", in_ready, 0);
    in_seq = 8;  #1; chk(!in_ready, "R2 distance 255 refused", in_ready, 0);

    @(negedge clk);
    dev_rsp_valid = 1; dev_rsp_seq = 8'h5A; dev_rsp_data = 32'hCAFE_0123;
    @(negedge clk); dev_rsp_valid = 0; #1;
    chk(cpu_ret_valid && cpu_ret_seq == 8'h5A && cpu_ret_data == 32'hCAFE_0123, "R9 tagged return",
        cpu_ret_data, 32'hCAFE_0123);
    step; chk(!cpu_ret_valid, "R9 single pulse", cpu_ret_valid, 0);

    for (int b = 0; b < 40; b++) begin
      int mul, add, cyc;
      base_abs = 9 + b * 16;
      for (int j = 0; j < 16; j++) em[j] = 0;
      mon_en = 1;
      mul = 2 * (b % 8) + 1;
      add = (b * 7) % 16;
      cyc = 0;
      for (int k = 0; k < 16; k++) begin
        int o, a;
        o = (k * mul + add) % 16;
        a = base_abs + o;
        @(negedge clk);
        out_ready = ((cyc * 5 + b) % 3) != 0; cyc++;
        in_valid = 1; in_seq = 8'(a); in_kind = kindf(a); in_addr = addrf(a); in_data = dataf(a);
        #1; chk(in_ready, "R2 in-window slot accepted", in_ready, 1);
      end
      for (int w = 0; w < 60; w++) begin
        @(negedge clk);
        in_valid = 0;
        out_ready = ((cyc * 5 + b) % 3) != 0; cyc++;
      end
      #4;
      begin
        int n;
        n = 0;
        for (int j = 0; j < 16; j++) n += em[j];
        chk(n == 16, "R7 batch fully emitted", n, 16);
      end
    end
    mon_en = 0;
    chk(total_emit == 640, "R10 every op across wraparound", total_emit, 640);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule